// File: doc/BRIEF.md
# JTAG Chain-Position Scan Wrapper

This block lets a scan stream written for a single JTAG device run unchanged when that device is one of several on a daisy chain. A requester issues one scan at a time. Each scan is an instruction or a data scan, with a bit length, the TDI bits, and optional expected TDO bits with a mask. The block drives TCK, TMS and TDI to the physical chain and samples TDO. It wraps the requested bits with bypass padding for every other device and hands back only the bits that came out of the target.

The chain layout is set by software through configuration inputs and is never probed. These inputs are the number of devices, the position of the target, and the instruction-register length of each device. Position 0 is the device next to TDO. Bits meant for lower positions leave the block first. In an instruction scan, every other device receives an all-ones instruction of its own length, which selects bypass. In a data scan, every other device adds one pad bit. After a scan, the requester receives the target's captured bits, aligned to bit 0, and a mismatch flag.

Top module: `jtag_chain_wrap`

## Requirements
- R1: After reset, and whenever no scan is running, req_ready_o is 1, tck_o is 0, tms_o is 0 and rsp_valid_o is 0.
- R2: In an instruction scan, the target receives the requested bits. Every other configured device ends up holding all-ones of its own configured IR length. The number of shift clocks is the requested length plus the IR lengths of all other devices.
- R3: In a data scan, each non-target device adds exactly one pad bit, driven as 1. The number of shift clocks is the requested length plus the device count minus one. The target's data register ends up holding the requested bits, LSB first.
- R4: rsp_tdo_o bit i is the i-th bit that the target shifted out. Pad bits from other devices never appear in it, and bits at or above the requested length read 0.
- R5: Each scan walks Run-Test/Idle, Select-DR, then Select-IR (instruction scans only), Capture, Shift, Exit1, Update and back to Run-Test/Idle. It uses exactly total+5 TCK rising edges for a data scan and total+6 for an instruction scan, and performs exactly one Update.
- R6: tms_o and tdi_o change only on the edge where tck_o falls, or while tck_o is low. They hold steady while tck_o is high.
- R7: TCK has a period of 2*(div+1) clk_i cycles, where div is cfg_div_i. The high phase and the low phase are equal.
- R8: rsp_mismatch_o is 1 exactly when some bit i below the requested length has req_mask_i[i]=1 and a captured bit that differs from req_exp_i[i].
- R9: A request is accepted in a cycle where req_valid_i and req_ready_o are both 1. The configuration and the request are sampled at acceptance, and later changes to them have no effect on that scan. rsp_valid_o is a one-cycle pulse, and req_ready_o is already 1 in that cycle.
- R10: Scans work with the target at position 0, with the target at the last position, and on a chain of a single device.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_dev_cnt_i | input | DEV_W | Number of devices on the chain (1..MAX_DEV) |
| cfg_target_i | input | DEV_W | Target position, 0 = next to TDO |
| cfg_ir_len_i | input | MAX_DEV*IRL_W | IR length per position, slice d at [d*IRL_W +: IRL_W] |
| cfg_div_i | input | DIV_W | TCK half-period minus one, in clk_i cycles |
| req_valid_i | input | 1 | Scan request present |
| req_ready_o | output | 1 | Block idle, request can be taken |
| req_is_ir_i | input | 1 | 1 = instruction scan, 0 = data scan |
| req_len_i | input | LEN_W | Target bit count (1..MAX_LEN) |
| req_tdi_i | input | MAX_LEN | Bits for the target, bit 0 shifted first |
| req_exp_i | input | MAX_LEN | Expected target TDO bits |
| req_mask_i | input | MAX_LEN | Compare enable per expected bit |
| rsp_valid_o | output | 1 | One-cycle pulse, scan finished |
| rsp_tdo_o | output | MAX_LEN | Target bits captured, bit 0 first out |
| rsp_mismatch_o | output | 1 | Masked compare failed |
| tck_o | output | 1 | Test clock |
| tms_o | output | 1 | Test mode select |
| tdi_o | output | 1 | Test data to chain |
| tdo_i | input | 1 | Test data from chain |

## Verification
The bench attaches a behavioural three-device chain with unequal IR lengths, and moves the target from the middle position to the TDO end and then to the TDI end. An error in the pad count or in the offset therefore shows up as a wrong instruction in one of the devices, or as a shifted response. It runs instruction scans and data scans back to back, because a data scan only reaches the target if the previous instruction scan set every other device to bypass. Masked compares are run with a matching value, with one wrong bit, and with that wrong bit masked off. Together these separate the compare from the capture path. A configuration change in the middle of a scan and a single-device chain check that the settings are sampled at acceptance and that the case with no padding at all works.

// File: rtl/jtag_wrap_pkg.sv
package jtag_wrap_pkg;

  typedef enum logic [2:0] {
    PH_WAIT,
    PH_SEL_DR,
    PH_SEL_IR,
    PH_CAPTURE,
    PH_SHIFT_ENTER,
    PH_SHIFT,
    PH_UPDATE,
    PH_IDLE
  } scan_phase_e;

endpackage

// File: rtl/jtag_tck_gen.sv
module jtag_tck_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tck_o,
  output logic             rise_o,
  output logic             fall_o
);

  logic [DIV_W-1:0] cnt_q;
  logic             tck_q;
  logic             hit;

  assign hit    = run_i && (cnt_q == div_i);
  assign rise_o = hit && !tck_q;
  assign fall_o = hit && tck_q;
  assign tck_o  = tck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tck_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      tck_q <= 1'b0;
    end else if (hit) begin
      cnt_q <= '0;
      tck_q <= ~tck_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/jtag_chain_calc.sv
module jtag_chain_calc #(
  parameter int MAX_DEV = 4,
  parameter int IRL_W   = 4,
  parameter int LEN_W   = 6,
  parameter int CNT_W   = 7,
  parameter int DEV_W   = 3
) (
  input  logic [DEV_W-1:0]         dev_cnt_i,
  input  logic [DEV_W-1:0]         target_i,
  input  logic [MAX_DEV*IRL_W-1:0] ir_len_i,
  input  logic                     is_ir_i,
  input  logic [LEN_W-1:0]         len_i,
  output logic [CNT_W-1:0]         pre_o,
  output logic [CNT_W-1:0]         total_o
);

  logic [CNT_W-1:0] seg [MAX_DEV];

  // segment length per chain position: absent, target, IR pad or bypass bit
  for (genvar g = 0; g < MAX_DEV; g++) begin : g_seg
    assign seg[g] = (DEV_W'(g) >= dev_cnt_i) ? '0 :
                    (DEV_W'(g) == target_i)  ? CNT_W'(len_i) :
                    is_ir_i                  ? CNT_W'(ir_len_i[g*IRL_W +: IRL_W]) :
                                               CNT_W'(1);
  end

  always_comb begin
    pre_o   = '0;
    total_o = '0;
    for (int d = 0; d < MAX_DEV; d++) begin
      total_o = total_o + seg[d];
      if (DEV_W'(d) < target_i) pre_o = pre_o + seg[d];
    end
  end

endmodule

// File: rtl/jtag_scan_seq.sv
module jtag_scan_seq
  import jtag_wrap_pkg::*;
#(
  parameter int MAX_LEN = 32,
  parameter int LEN_W   = 6,
  parameter int CNT_W   = 7,
  parameter int DIV_W   = 8,
  parameter int IDX_W   = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               is_ir_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic [MAX_LEN-1:0] tdi_i,
  input  logic [MAX_LEN-1:0] exp_i,
  input  logic [MAX_LEN-1:0] mask_i,
  input  logic [CNT_W-1:0]   pre_i,
  input  logic [CNT_W-1:0]   total_i,
  input  logic [DIV_W-1:0]   div_i,
  input  logic               rise_i,
  input  logic               fall_i,
  input  logic               tdo_i,
  output logic               busy_o,
  output logic [DIV_W-1:0]   div_o,
  output logic               tms_o,
  output logic               tdi_o,
  output logic               done_o,
  output logic [MAX_LEN-1:0] rsp_tdo_o,
  output logic               mismatch_o
);

  localparam logic [CNT_W-1:0] CntOne = CNT_W'(1);

  scan_phase_e        phase_q;
  logic [CNT_W-1:0]   cnt_q, pre_q, total_q, len_q;
  logic               is_ir_q, mis_q, done_q;
  logic [DIV_W-1:0]   div_q;
  logic [MAX_LEN-1:0] tdi_q, exp_q, mask_q, cap_q;
  logic               in_win, last_bit;
  logic [IDX_W-1:0]   idx;

  assign in_win   = (cnt_q >= pre_q) && (cnt_q < pre_q + len_q);
  assign idx      = IDX_W'(cnt_q - pre_q);
  assign last_bit = (cnt_q == total_q - CntOne);

  assign busy_o     = (phase_q != PH_WAIT);
  assign div_o      = div_q;
  assign done_o     = done_q;
  assign rsp_tdo_o  = cap_q;
  assign mismatch_o = mis_q;

  always_comb begin
    unique case (phase_q)
      PH_SEL_DR, PH_SEL_IR, PH_UPDATE: tms_o = 1'b1;
      PH_SHIFT:                        tms_o = last_bit;
      default:                         tms_o = 1'b0;
    endcase
  end

  // pad positions and non-shift steps drive 1
  assign tdi_o = (phase_q == PH_SHIFT && in_win) ? tdi_q[idx] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_WAIT;
      cnt_q   <= '0;
      pre_q   <= '0;
      total_q <= '0;
      len_q   <= '0;
      is_ir_q <= 1'b0;
      div_q   <= '0;
      tdi_q   <= '0;
      exp_q   <= '0;
      mask_q  <= '0;
      cap_q   <= '0;
      mis_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        phase_q <= PH_SEL_DR;
        cnt_q   <= '0;
        pre_q   <= pre_i;
        total_q <= total_i;
        len_q   <= CNT_W'(len_i);
        is_ir_q <= is_ir_i;
        div_q   <= div_i;
        tdi_q   <= tdi_i;
        exp_q   <= exp_i;
        mask_q  <= mask_i;
        cap_q   <= '0;
        mis_q   <= 1'b0;
      end else begin
        if (rise_i && phase_q == PH_SHIFT && in_win) begin
          cap_q[idx] <= tdo_i;
          if (mask_q[idx] && (tdo_i != exp_q[idx])) mis_q <= 1'b1;
        end
        if (fall_i) begin
          unique case (phase_q)
            PH_SEL_DR:      phase_q <= is_ir_q ? PH_SEL_IR : PH_CAPTURE;
            PH_SEL_IR:      phase_q <= PH_CAPTURE;
            PH_CAPTURE:     phase_q <= PH_SHIFT_ENTER;
            PH_SHIFT_ENTER: begin
              phase_q <= PH_SHIFT;
              cnt_q   <= '0;
            end
            PH_SHIFT: begin
              if (last_bit) phase_q <= PH_UPDATE;
              else          cnt_q   <= cnt_q + CntOne;
            end
            PH_UPDATE:      phase_q <= PH_IDLE;
            PH_IDLE: begin
              phase_q <= PH_WAIT;
              done_q  <= 1'b1;
            end
            default: ;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/jtag_chain_wrap.sv
module jtag_chain_wrap #(
  parameter int MAX_DEV = 4,
  parameter int MAX_IR  = 8,
  parameter int MAX_LEN = 32,
  parameter int DIV_W   = 8,
  localparam int DEV_W  = $clog2(MAX_DEV + 1),
  localparam int IRL_W  = $clog2(MAX_IR + 1),
  localparam int LEN_W  = $clog2(MAX_LEN + 1),
  localparam int IDX_W  = $clog2(MAX_LEN),
  localparam int CNT_W  = $clog2(MAX_LEN + MAX_DEV * MAX_IR + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [DEV_W-1:0]         cfg_dev_cnt_i,
  input  logic [DEV_W-1:0]         cfg_target_i,
  input  logic [MAX_DEV*IRL_W-1:0] cfg_ir_len_i,
  input  logic [DIV_W-1:0]         cfg_div_i,
  input  logic                     req_valid_i,
  output logic                     req_ready_o,
  input  logic                     req_is_ir_i,
  input  logic [LEN_W-1:0]         req_len_i,
  input  logic [MAX_LEN-1:0]       req_tdi_i,
  input  logic [MAX_LEN-1:0]       req_exp_i,
  input  logic [MAX_LEN-1:0]       req_mask_i,
  output logic                     rsp_valid_o,
  output logic [MAX_LEN-1:0]       rsp_tdo_o,
  output logic                     rsp_mismatch_o,
  output logic                     tck_o,
  output logic                     tms_o,
  output logic                     tdi_o,
  input  logic                     tdo_i
);

  logic             busy, start, rise, fall;
  logic [CNT_W-1:0] pre, total;
  logic [DIV_W-1:0] div_run;

  assign req_ready_o = !busy;
  assign start       = req_valid_i && !busy;

  jtag_chain_calc #(
    .MAX_DEV (MAX_DEV),
    .IRL_W   (IRL_W),
    .LEN_W   (LEN_W),
    .CNT_W   (CNT_W),
    .DEV_W   (DEV_W)
  ) i_calc (
    .dev_cnt_i (cfg_dev_cnt_i),
    .target_i  (cfg_target_i),
    .ir_len_i  (cfg_ir_len_i),
    .is_ir_i   (req_is_ir_i),
    .len_i     (req_len_i),
    .pre_o     (pre),
    .total_o   (total)
  );

  jtag_scan_seq #(
    .MAX_LEN (MAX_LEN),
    .LEN_W   (LEN_W),
    .CNT_W   (CNT_W),
    .DIV_W   (DIV_W),
    .IDX_W   (IDX_W)
  ) i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .is_ir_i    (req_is_ir_i),
    .len_i      (req_len_i),
    .tdi_i      (req_tdi_i),
    .exp_i      (req_exp_i),
    .mask_i     (req_mask_i),
    .pre_i      (pre),
    .total_i    (total),
    .div_i      (cfg_div_i),
    .rise_i     (rise),
    .fall_i     (fall),
    .tdo_i      (tdo_i),
    .busy_o     (busy),
    .div_o      (div_run),
    .tms_o      (tms_o),
    .tdi_o      (tdi_o),
    .done_o     (rsp_valid_o),
    .rsp_tdo_o  (rsp_tdo_o),
    .mismatch_o (rsp_mismatch_o)
  );

  jtag_tck_gen #(
    .DIV_W (DIV_W)
  ) i_tck (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy),
    .div_i  (div_run),
    .tck_o  (tck_o),
    .rise_o (rise),
    .fall_o (fall)
  );

endmodule

// File: rtl/jtag_chain_wrap_chk.sv
module jtag_chain_wrap_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tck_o,
  input logic tms_o,
  input logic tdi_o,
  input logic req_ready_o,
  input logic rsp_valid_o
);

  // R1
  idle_tck_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!tck_o && !tms_o));

  // R6
  tms_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tck_o && $past(tck_o)) |-> ($stable(tms_o) && $stable(tdi_o)));

  // R6
  tms_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(tms_o) || !$stable(tdi_o)) |-> !tck_o);

  // R9
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  // R9
  rsp_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> req_ready_o);

endmodule

bind jtag_chain_wrap jtag_chain_wrap_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tck_o       (tck_o),
  .tms_o       (tms_o),
  .tdi_o       (tdi_o),
  .req_ready_o (req_ready_o),
  .rsp_valid_o (rsp_valid_o)
);

// File: tb/test_jtag_chain_wrap.sv
module test_jtag_chain_wrap;

  localparam int DRL = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  cfg_dev_cnt, cfg_target;
  logic [15:0] cfg_ir_len;
  logic [7:0]  cfg_div;
  logic        req_valid, req_ready, req_is_ir;
  logic [5:0]  req_len;
  logic [31:0] req_tdi, req_exp, req_mask;
  logic        rsp_valid, rsp_mis;
  logic [31:0] rsp_tdo;
  logic        tck, tms, tdi;
  logic        m_tdo;

  int checks = 0;
  int errors = 0;

  always #10ns clk = ~clk;

  jtag_chain_wrap i_jtag_chain_wrap (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .cfg_dev_cnt_i  (cfg_dev_cnt),
    .cfg_target_i   (cfg_target),
    .cfg_ir_len_i   (cfg_ir_len),
    .cfg_div_i      (cfg_div),
    .req_valid_i    (req_valid),
    .req_ready_o    (req_ready),
    .req_is_ir_i    (req_is_ir),
    .req_len_i      (req_len),
    .req_tdi_i      (req_tdi),
    .req_exp_i      (req_exp),
    .req_mask_i     (req_mask),
    .rsp_valid_o    (rsp_valid),
    .rsp_tdo_o      (rsp_tdo),
    .rsp_mismatch_o (rsp_mis),
    .tck_o          (tck),
    .tms_o          (tms),
    .tdi_o          (tdi),
    .tdo_i          (m_tdo)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", what, act, exp);
    end
  endtask

  // ---------------- behavioural chain, position 0 next to TDO ----------------
  typedef enum logic [3:0] {
    TLR, RTI, SDS, CDR, SHDR, E1DR, PDR, E2DR, UDR,
    SIS, CIR, SHIR, E1IR, PIR, E2IR, UIR
  } tap_e;

  tap_e        m_st = RTI;
  int          m_ndev = 3;
  int          m_irlen [4];
  logic [15:0] m_ir [4];
  logic [15:0] m_irsh [4];
  logic [15:0] m_drsh [4];
  logic [15:0] m_upd [4];
  logic [15:0] m_stat [4];
  logic [4:0]  outs;
  int          shift_cnt, rise_cnt, upd_cnt;
  int          cyc = 0, last_rise, per_min, per_max;

  function automatic tap_e nxt(tap_e s, logic t);
    case (s)
      TLR:  return t ? TLR  : RTI;
      RTI:  return t ? SDS  : RTI;
      SDS:  return t ? SIS  : CDR;
      CDR:  return t ? E1DR : SHDR;
      SHDR: return t ? E1DR : SHDR;
      E1DR: return t ? UDR  : PDR;
      PDR:  return t ? E2DR : PDR;
      E2DR: return t ? UDR  : SHDR;
      UDR:  return t ? SDS  : RTI;
      SIS:  return t ? TLR  : CIR;
      CIR:  return t ? E1IR : SHIR;
      SHIR: return t ? E1IR : SHIR;
      E1IR: return t ? UIR  : PIR;
      PIR:  return t ? E2IR : PIR;
      E2IR: return t ? UIR  : SHIR;
      default: return t ? SDS : RTI;
    endcase
  endfunction

  function automatic bit byp(int d);
    return m_ir[d] == ((16'h1 << m_irlen[d]) - 16'h1);
  endfunction

  always @(negedge clk) cyc++;

  always_comb begin
    for (int d = 0; d < 4; d++) cfg_ir_len[d*4 +: 4] = 4'(m_irlen[d]);
  end

  always @(posedge tck) begin
    rise_cnt++;
    if (last_rise >= 0) begin
      if (cyc - last_rise < per_min) per_min = cyc - last_rise;
      if (cyc - last_rise > per_max) per_max = cyc - last_rise;
    end
    last_rise = cyc;
    case (m_st)
      CDR: for (int d = 0; d < m_ndev; d++) m_drsh[d] = byp(d) ? 16'h0 : m_stat[d];
      CIR: for (int d = 0; d < m_ndev; d++) m_irsh[d] = 16'h1;
      SHDR: begin
        for (int d = 0; d < m_ndev; d++) outs[d] = m_drsh[d][0];
        for (int d = 0; d < m_ndev; d++) begin
          logic b;
          int   ln;
          b  = (d == m_ndev - 1) ? tdi : outs[d+1];
          ln = byp(d) ? 1 : DRL;
          m_drsh[d] = (m_drsh[d] >> 1) | (16'(b) << (ln - 1));
        end
        shift_cnt++;
      end
      SHIR: begin
        for (int d = 0; d < m_ndev; d++) outs[d] = m_irsh[d][0];
        for (int d = 0; d < m_ndev; d++) begin
          logic b;
          b = (d == m_ndev - 1) ? tdi : outs[d+1];
          m_irsh[d] = (m_irsh[d] >> 1) | (16'(b) << (m_irlen[d] - 1));
        end
        shift_cnt++;
      end
      UDR: begin
        for (int d = 0; d < m_ndev; d++) if (!byp(d)) m_upd[d] = m_drsh[d];
        upd_cnt++;
      end
      UIR: begin
        for (int d = 0; d < m_ndev; d++) m_ir[d] = m_irsh[d];
        upd_cnt++;
      end
      default: ;
    endcase
    m_st = nxt(m_st, tms);
  end

  always @(negedge tck) begin
    m_tdo = (m_st == SHDR) ? m_drsh[0][0] : (m_st == SHIR) ? m_irsh[0][0] : 1'b1;
  end

  // ---------------- scoreboard ----------------
  typedef struct packed {
    logic [31:0] tdo;
    logic        mis;
  } sb_t;

  sb_t sb_q [$];
  int  rsp_cnt = 0;

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb_q.size() == 0) begin
        chk("R9 unexpected response", 32'h1, 32'h0);
      end else begin
        sb_t e;
        e = sb_q.pop_front();
        chk("R4 realigned target bits", rsp_tdo, e.tdo);
        chk("R8 mismatch flag", 32'(rsp_mis), 32'(e.mis));
      end
      rsp_cnt++;
    end
  end

  task automatic scan(input bit is_ir, input int len, input logic [31:0] tdi_v,
                      input logic [31:0] ex, input logic [31:0] mk,
                      input logic [31:0] exp_tdo, input bit exp_mis,
                      input int exp_shift, input int exp_per, input bit mid);
    sb_t e;
    int  start;
    e.tdo = exp_tdo;
    e.mis = exp_mis;
    sb_q.push_back(e);
    shift_cnt = 0; rise_cnt = 0; upd_cnt = 0;
    per_min = 1000; per_max = 0; last_rise = -1;
    start = rsp_cnt;
    @(negedge clk);
    req_is_ir = is_ir; req_len = 6'(len); req_tdi = tdi_v;
    req_exp = ex; req_mask = mk; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (mid) begin
      cfg_target = 3'd0; cfg_dev_cnt = 3'd1; cfg_div = 8'd5;
    end
    while (rsp_cnt == start) @(negedge clk);
    // R2 R3 shift clocks equal padded total
    chk(is_ir ? "R2 shift count" : "R3 shift count", shift_cnt, exp_shift);
    chk("R5 rising edges per scan", rise_cnt, exp_shift + (is_ir ? 6 : 5));
    chk("R5 single update", upd_cnt, 1);
    chk("R7 tck period min", per_min, exp_per);
    chk("R7 tck period max", per_max, exp_per);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_is_ir = 1'b0; req_len = '0;
    req_tdi = '0; req_exp = '0; req_mask = '0;
    cfg_dev_cnt = 3'd3; cfg_target = 3'd1; cfg_div = 8'd1;
    m_irlen[0] = 4; m_irlen[1] = 6; m_irlen[2] = 5; m_irlen[3] = 4;
    for (int d = 0; d < 4; d++) begin
      m_ir[d] = (16'h1 << m_irlen[d]) - 16'h1;
      m_irsh[d] = '0; m_drsh[d] = '0; m_upd[d] = '0;
    end
    m_stat[0] = 16'hE1; m_stat[1] = 16'h5A; m_stat[2] = 16'h77; m_stat[3] = 16'h00;
    m_tdo = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 idle state after reset
    chk("R1 ready after reset", 32'(req_ready), 32'h1);
    chk("R1 tck low", 32'(tck), 32'h0);
    chk("R1 tms low", 32'(tms), 32'h0);
    chk("R1 no response", 32'(rsp_valid), 32'h0);

    // middle target, IR pads 4 + 5 around a 6-bit instruction; capture pattern 01
    scan(1'b1, 6, 32'h2A, 0, 0, 32'h1, 1'b0, 15, 4, 1'b0);
    chk("R2 pos0 bypass", m_ir[0], 16'hF);
    chk("R2 target instr", m_ir[1], 16'h2A);
    chk("R2 pos2 bypass", m_ir[2], 16'h1F);
    chk("R1 idle between scans", 32'(tck), 32'h0);

    // data scans, one pad bit per bypassed device
    scan(1'b0, 8, 32'hC3, 32'h5A, 32'hFF, 32'h5A, 1'b0, 10, 4, 1'b0);
    chk("R3 target data", m_upd[1], 16'hC3);
    scan(1'b0, 8, 32'h11, 32'h5B, 32'hFF, 32'h5A, 1'b1, 10, 4, 1'b0); // R8 one bit off
    scan(1'b0, 8, 32'h22, 32'h5B, 32'hFE, 32'h5A, 1'b0, 10, 4, 1'b0); // R8 masked off
    chk("R3 target data", m_upd[1], 16'h22);

    // R10 target next to TDO
    cfg_target = 3'd0;
    scan(1'b1, 4, 32'h3, 0, 0, 32'h1, 1'b0, 15, 4, 1'b0);
    chk("R10 pos0 instr", m_ir[0], 16'h3);
    chk("R2 pos1 bypass", m_ir[1], 16'h3F);
    chk("R2 pos2 bypass", m_ir[2], 16'h1F);
    scan(1'b0, 8, 32'h96, 32'hE1, 32'hFF, 32'hE1, 1'b0, 10, 4, 1'b0);
    chk("R10 pos0 data", m_upd[0], 16'h96);

    // R10 target next to TDI, fastest TCK (R7)
    cfg_target = 3'd2; cfg_div = 8'd0;
    scan(1'b1, 5, 32'h0A, 0, 0, 32'h1, 1'b0, 15, 2, 1'b0);
    chk("R10 pos2 instr", m_ir[2], 16'h0A);
    chk("R2 pos0 bypass", m_ir[0], 16'hF);
    chk("R2 pos1 bypass", m_ir[1], 16'h3F);
    scan(1'b0, 8, 32'h3C, 0, 0, 32'h77, 1'b0, 10, 2, 1'b0);
    chk("R10 pos2 data", m_upd[2], 16'h3C);

    // R9 configuration changed after acceptance has no effect
    scan(1'b0, 8, 32'h81, 0, 0, 32'h77, 1'b0, 10, 2, 1'b1);
    chk("R9 latched target data", m_upd[2], 16'h81);
    chk("R9 other device untouched", m_upd[0], 16'h96);

    // R10 single-device chain, no padding
    m_ndev = 1; cfg_dev_cnt = 3'd1; cfg_target = 3'd0; cfg_div = 8'd2;
    scan(1'b1, 4, 32'h5, 0, 0, 32'h1, 1'b0, 4, 6, 1'b0);
    chk("R10 single instr", m_ir[0], 16'h5);
    scan(1'b0, 8, 32'h42, 32'hE1, 32'hFF, 32'hE1, 1'b0, 8, 6, 1'b0);
    chk("R10 single data", m_upd[0], 16'h42);
    chk("R9 scoreboard drained", sb_q.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule